// File: doc/BRIEF.md
# Shared Event Flag Register

This block holds one event word that several cores share. The upper slice of the word is never stored. It is computed every cycle from the fill levels of a set of FIFOs. The host sets up a rule for each of those level flags: which FIFO it watches, a threshold, and whether the flag means "at or above" or "at or below" that threshold. The lower slice holds software flags. Any core can raise them through its set port and drop them through its clear port, and several cores may do so in the same cycle.

Each core has its own sensitivity mask. A core waits on the word by holding its wait request high. The block answers in the same cycle, raising that core's done line as soon as the core's mask and the current event word share a set bit. Alongside done, the core receives the whole event word without the mask applied. While no masked bit is set, done stays low and the core is expected to hold its request, which stalls it. The decision is made separately for each core, so several cores can be released on one edge.

Top module: `evt_flag_hub`

## Requirements
- R1: Event bit 24+k is level flag k, with k from 0 to 7. Flag k reads the 4-bit level of FIFO `cfg_fifo_sel[2k+1:2k]`, where FIFO i's level sits at `fifo_level[4i+3:4i]`. The flag is 1 when that level is at or above `cfg_thresh[4k+3:4k]` (while `cfg_at_or_below[k]`=0) or at or below it (while `cfg_at_or_below[k]`=1). It follows its inputs in the same cycle.
- R2: A core that asserts `set_we` with data D makes every event bit in [23:0] that is 1 in D read as 1 from the next cycle on. Bits [31:24] of D change nothing.
- R3: A core that asserts `clr_we` with data D makes every event bit in [23:0] that is 1 in D read as 0 from the next cycle on. Bits [31:24] of D change nothing.
- R4: Set writes from different cores in the same cycle all take effect, as do clear writes.
- R5: When a set and a clear name the same bit in the same cycle, from the same core or from different cores, the bit reads 1 afterwards.
- R6: `mask_we` loads that core's mask from `mask_data`. The new mask is first used one cycle later.
- R7: `wait_done[c]` is 1 in exactly the cycles where `wait_req[c]` is 1 and core c's mask shares a set bit with the current event word. Otherwise the core stays stalled.
- R8: The value a core receives on `wait_data` is the full event word, not masked.
- R9: Each core's wait is decided on its own, and any number of cores may see done in the same cycle.
- R10: Reset clears all software event bits and every mask, so no wait completes until a mask has been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_level | input | 16 | Current fill of FIFO i at [4i+3:4i] |
| cfg_fifo_sel | input | 16 | FIFO chosen for each level flag, 2 bits per flag |
| cfg_thresh | input | 32 | Threshold for each level flag, 4 bits per flag |
| cfg_at_or_below | input | 8 | Compare sense for each flag: 1 = at or below, 0 = at or above |
| set_we | input | 4 | Per-core strobe for a set write |
| set_data | input | 128 | Per-core set pattern, core c at [32c+31:32c] |
| clr_we | input | 4 | Per-core strobe for a clear write |
| clr_data | input | 128 | Per-core clear pattern, core c at [32c+31:32c] |
| mask_we | input | 4 | Per-core strobe for a mask write |
| mask_data | input | 128 | Per-core mask value |
| wait_req | input | 4 | Per-core request to wait on the event word |
| wait_done | output | 4 | Per-core release; the wait completes in this cycle |
| wait_data | output | 128 | Per-core returned event word, unmasked |
| events_o | output | 32 | Current event word |

## Verification
Single directed writes show whether set and clear act only on the lower 24 bits. Writes from two cores in the same cycle show whether the cores' requests are merged. Set and clear aimed at one bit in one cycle show which of the two wins. The threshold inputs are driven to one below, equal to and one above each threshold, in both compare senses, which exposes off-by-one and reversed comparisons. A wait that stalls and is then released by another core's set shows whether the mask is applied with the right latency. A shared bit released for three cores at once shows whether the per-core decisions are independent. A long stretch of mixed random writes, waits and FIFO levels is compared every cycle against a behavioural model.

// File: rtl/evt_pkg.sv
package evt_pkg;

  // Threshold test for one level flag; widths are zero-extended to 16 bits.
  function automatic logic level_hit(input logic [15:0] level,
                                     input logic [15:0] thresh,
                                     input logic        at_or_below);
    if (at_or_below) return (level <= thresh);
    return (level >= thresh);
  endfunction

endpackage

// File: rtl/evt_level_cmp.sv
module evt_level_cmp #(
  parameter int NF    = 8,
  parameter int NQ    = 4,
  parameter int LW    = 4,
  parameter int SEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NQ*LW-1:0]  fifo_level,
  input  logic [NF*SEL_W-1:0] cfg_sel,
  input  logic [NF*LW-1:0]  cfg_thresh,
  input  logic [NF-1:0]     cfg_below,
  output logic [NF-1:0]     flags
);

  for (genvar k = 0; k < NF; k++) begin : g_flag
    logic [SEL_W-1:0] sel;
    logic [LW-1:0]    lvl;
    assign sel = cfg_sel[k*SEL_W +: SEL_W];
    assign lvl = (int'(sel) < NQ) ? fifo_level[int'(sel)*LW +: LW] : '0;
    assign flags[k] = evt_pkg::level_hit(16'(lvl), 16'(cfg_thresh[k*LW +: LW]),
                                         cfg_below[k]);
  end

  // R1
  lvl_flag_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(fifo_level) && $stable(cfg_sel) && $stable(cfg_thresh) && $stable(cfg_below))
      |-> $stable(flags));

endmodule

// File: rtl/evt_sw_reg.sv
module evt_sw_reg #(
  parameter int NC = 4,
  parameter int EW = 32,
  parameter int SW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NC-1:0]    set_we,
  input  logic [NC*EW-1:0] set_data,
  input  logic [NC-1:0]    clr_we,
  input  logic [NC*EW-1:0] clr_data,
  output logic [SW-1:0]    sw_q
);

  logic [EW-1:0] set_all, clr_all;
  logic [SW-1:0] set_lo, clr_lo;
  logic          unused_hi;

  // Next software flag state; set is applied after clear so set wins.
  function automatic logic [SW-1:0] next_bits(input logic [SW-1:0] cur,
                                              input logic [SW-1:0] s,
                                              input logic [SW-1:0] c);
    return (cur & ~c) | s;
  endfunction

  always_comb begin
    set_all = '0;
    clr_all = '0;
    for (int c = 0; c < NC; c++) begin
      if (set_we[c]) set_all = set_all | set_data[c*EW +: EW];
      if (clr_we[c]) clr_all = clr_all | clr_data[c*EW +: EW];
    end
  end

  assign set_lo    = set_all[SW-1:0];
  assign clr_lo    = clr_all[SW-1:0];
  assign unused_hi = ^{set_all[EW-1:SW], clr_all[EW-1:SW]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= '0;
    else        sw_q <= next_bits(sw_q, set_lo, clr_lo);
  end

  // R2
  sw_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_lo == '0 && clr_lo == '0) |=> $stable(sw_q));

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sw_q & $past(set_lo)) == $past(set_lo)));

  // R3
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sw_q & ($past(clr_lo) & ~$past(set_lo))) == '0));

  // R10
  sw_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sw_q == '0));

endmodule

// File: rtl/evt_waiter.sv
module evt_waiter #(
  parameter int EW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] events,
  input  logic          mask_we,
  input  logic [EW-1:0] mask_data,
  input  logic          wait_req,
  output logic          wait_done,
  output logic [EW-1:0] wait_data
);

  logic [EW-1:0] mask_q;
  logic          hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_data;
  end

  assign hit       = |(mask_q & events);
  assign wait_done = wait_req & hit;
  assign wait_data = events;

  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(mask_data)));

  // R10
  mask_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask_q == '0));

endmodule

// File: rtl/evt_flag_hub.sv
module evt_flag_hub #(
  parameter int NC = 4,
  parameter int EW = 32,
  parameter int NF = 8,
  parameter int NQ = 4,
  parameter int LW = 4,
  localparam int SW    = EW - NF,
  localparam int SEL_W = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NQ*LW-1:0]    fifo_level,
  input  logic [NF*SEL_W-1:0] cfg_fifo_sel,
  input  logic [NF*LW-1:0]    cfg_thresh,
  input  logic [NF-1:0]       cfg_at_or_below,
  input  logic [NC-1:0]       set_we,
  input  logic [NC*EW-1:0]    set_data,
  input  logic [NC-1:0]       clr_we,
  input  logic [NC*EW-1:0]    clr_data,
  input  logic [NC-1:0]       mask_we,
  input  logic [NC*EW-1:0]    mask_data,
  input  logic [NC-1:0]       wait_req,
  output logic [NC-1:0]       wait_done,
  output logic [NC*EW-1:0]    wait_data,
  output logic [EW-1:0]       events_o
);

  logic [NF-1:0] lvl_flags;
  logic [SW-1:0] sw_q;
  logic [EW-1:0] events;

  evt_level_cmp #(.NF(NF), .NQ(NQ), .LW(LW), .SEL_W(SEL_W)) lvl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_level (fifo_level),
    .cfg_sel    (cfg_fifo_sel),
    .cfg_thresh (cfg_thresh),
    .cfg_below  (cfg_at_or_below),
    .flags      (lvl_flags)
  );

  evt_sw_reg #(.NC(NC), .EW(EW), .SW(SW)) sw_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_we   (set_we),
    .set_data (set_data),
    .clr_we   (clr_we),
    .clr_data (clr_data),
    .sw_q     (sw_q)
  );

  assign events   = {lvl_flags, sw_q};
  assign events_o = events;

  for (genvar c = 0; c < NC; c++) begin : g_core
    evt_waiter #(.EW(EW)) wt_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .events    (events),
      .mask_we   (mask_we[c]),
      .mask_data (mask_data[c*EW +: EW]),
      .wait_req  (wait_req[c]),
      .wait_done (wait_done[c]),
      .wait_data (wait_data[c*EW +: EW])
    );
  end

  // R9
  release_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wait_done & ~wait_req) == '0));

endmodule

// File: tb/evt_flag_hub_tb_top.sv
`timescale 1ns/1ps
module evt_flag_hub_tb_top;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   fifo_level = '0;
  logic [15:0]   cfg_fifo_sel = '0;
  logic [31:0]   cfg_thresh = '0;
  logic [7:0]    cfg_at_or_below = '0;
  logic [3:0]    set_we = '0;
  logic [127:0]  set_data = '0;
  logic [3:0]    clr_we = '0;
  logic [127:0]  clr_data = '0;
  logic [3:0]    mask_we = '0;
  logic [127:0]  mask_data = '0;
  logic [3:0]    wait_req = '0;
  logic [3:0]    wait_done;
  logic [127:0]  wait_data;
  logic [31:0]   events_o;

  int checks = 0;
  int fails = 0;
  bit running = 1'b0;
  bit finished = 1'b0;
  string cur_tag = "R1";

  logic [31:0] m_sw = '0;
  logic [31:0] m_mask [4];

  always #2.5 clk = ~clk;

  evt_flag_hub dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .cfg_fifo_sel(cfg_fifo_sel),
    .cfg_thresh(cfg_thresh), .cfg_at_or_below(cfg_at_or_below),
    .set_we(set_we), .set_data(set_data), .clr_we(clr_we), .clr_data(clr_data),
    .mask_we(mask_we), .mask_data(mask_data), .wait_req(wait_req),
    .wait_done(wait_done), .wait_data(wait_data), .events_o(events_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural model of the level flags
  function automatic logic [7:0] m_flags();
    logic [7:0] f;
    for (int k = 0; k < 8; k++) begin
      int s, lv, th;
      s  = int'(cfg_fifo_sel[k*2 +: 2]);
      lv = int'(fifo_level[s*4 +: 4]);
      th = int'(cfg_thresh[k*4 +: 4]);
      if (cfg_at_or_below[k]) f[k] = (lv <= th);
      else                    f[k] = (lv >= th);
    end
    return f;
  endfunction

  function automatic logic [31:0] m_events();
    return {m_flags(), m_sw[23:0]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sw = '0;
      for (int c = 0; c < 4; c++) m_mask[c] = '0;
    end else begin
      logic [31:0] sv, cv;
      sv = '0;
      cv = '0;
      for (int c = 0; c < 4; c++) begin
        if (set_we[c]) sv = sv | set_data[c*32 +: 32];
        if (clr_we[c]) cv = cv | clr_data[c*32 +: 32];
      end
      m_sw = ((m_sw & ~cv) | sv) & 32'h00FF_FFFF;
      for (int c = 0; c < 4; c++) if (mask_we[c]) m_mask[c] = mask_data[c*32 +: 32];
    end
  end

  always @(negedge clk) begin
    if (rst_n && running) begin
      logic [31:0] e;
      e = m_events();
      chk(cur_tag, events_o, e);
      for (int c = 0; c < 4; c++) begin
        chk(cur_tag, {31'b0, wait_done[c]},
            {31'b0, (wait_req[c] && ((m_mask[c] & e) != 0))});
        if (wait_req[c]) chk(cur_tag, wait_data[c*32 +: 32], e);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
    set_we  = '0;
    clr_we  = '0;
    mask_we = '0;
  endtask

  task automatic do_set(input int c, input logic [31:0] v);
    set_we[c] = 1'b1;
    set_data[c*32 +: 32] = v;
  endtask

  task automatic do_clr(input int c, input logic [31:0] v);
    clr_we[c] = 1'b1;
    clr_data[c*32 +: 32] = v;
  endtask

  task automatic do_mask(input int c, input logic [31:0] v);
    mask_we[c] = 1'b1;
    mask_data[c*32 +: 32] = v;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) begin
      cfg_fifo_sel[k*2 +: 2] = 2'(k % 4);
      cfg_thresh[k*4 +: 4]   = 4'd8;
    end
    cfg_thresh[3:0]   = 4'd0;          // flag0: level >= 0, always on
    cfg_thresh[7:4]   = 4'd5;          // flag1: FIFO1 >= 5
    cfg_thresh[11:8]  = 4'd3;          // flag2: FIFO2 <= 3
    cfg_at_or_below[2] = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    running = 1'b1;

    // R10: reset state; level flags 0 and 2 active with all levels 0
    cur_tag = "R10";
    wait_req = 4'hF;
    @(negedge clk);
    chk("R10 events after reset", events_o, 32'h0500_0000);
    chk("R10 no release with cleared masks", {28'b0, wait_done}, 32'h0);
    tick();
    wait_req = '0;

    // R6: mask written this cycle not yet used
    cur_tag = "R6";
    do_mask(0, 32'h0100_0000);
    wait_req[0] = 1'b1;
    @(negedge clk);
    chk("R6 mask not yet active", {31'b0, wait_done[0]}, 32'h0);
    tick();
    @(negedge clk);
    chk("R6 R7 release after mask", {31'b0, wait_done[0]}, 32'h1);
    chk("R8 unmasked value returned", wait_data[31:0], 32'h0500_0000);
    tick();
    wait_req = '0;

    // R2: set, upper bits ignored
    cur_tag = "R2";
    do_set(1, 32'hFF00_0013);
    tick();
    @(negedge clk);
    chk("R2 set low bits only", events_o, 32'h0500_0013);

    // R3: clear, upper bits ignored
    cur_tag = "R3";
    do_clr(2, 32'hFFFF_FF01);
    tick();
    @(negedge clk);
    chk("R3 clear low bits only", events_o, 32'h0500_0012);

    // R4: two cores set together
    cur_tag = "R4";
    do_set(0, 32'h0000_0100);
    do_set(3, 32'h0000_8000);
    tick();
    @(negedge clk);
    chk("R4 merged sets", events_o, 32'h0500_8112);

    // R5: set against clear on the same bit
    cur_tag = "R5";
    do_set(1, 32'h0000_0002);
    do_clr(2, 32'h0000_0012);
    do_set(0, 32'h0000_0004);
    do_clr(0, 32'h0000_0004);
    tick();
    @(negedge clk);
    chk("R5 set wins", events_o, 32'h0500_8106);

    // R1: threshold boundaries, both senses
    cur_tag = "R1";
    fifo_level[7:4] = 4'd4; fifo_level[11:8] = 4'd3;
    @(negedge clk);
    chk("R1 below >= thr / at <= thr", {24'b0, events_o[31:24]}, 32'h05);
    tick();
    fifo_level[7:4] = 4'd5; fifo_level[11:8] = 4'd4;
    @(negedge clk);
    chk("R1 at >= thr / above <= thr", {24'b0, events_o[31:24]}, 32'h03);
    tick();
    fifo_level[7:4] = 4'd6; fifo_level[11:8] = 4'd2;
    fifo_level[15:12] = 4'd8;
    @(negedge clk);
    chk("R1 above / below / full", {24'b0, events_o[31:24]}, 32'h8F);
    tick();
    fifo_level = '0;

    // R7: stall until another core sets the watched bit
    cur_tag = "R7";
    do_mask(2, 32'h0000_0800);
    tick();
    wait_req[2] = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R7 stalled", {31'b0, wait_done[2]}, 32'h0);
      tick();
    end
    do_set(3, 32'h0000_0800);
    @(negedge clk);
    chk("R7 still stalled on set cycle", {31'b0, wait_done[2]}, 32'h0);
    tick();
    @(negedge clk);
    chk("R7 released", {31'b0, wait_done[2]}, 32'h1);
    tick();
    wait_req = '0;

    // R9: simultaneous release of several cores
    cur_tag = "R9";
    for (int c = 1; c < 4; c++) do_mask(c, 32'h0001_0000);
    tick();
    wait_req = 4'hE;
    @(negedge clk);
    chk("R9 none before set", {28'b0, wait_done}, 32'h0);
    do_set(0, 32'h0001_0000);
    tick();
    wait_req = 4'hF;
    @(negedge clk);
    chk("R9 all released together", {28'b0, wait_done}, 32'hF);
    tick();
    wait_req = '0;

    // R9 R4: mixed random traffic against the model
    cur_tag = "R9 random";
    for (int i = 0; i < 500; i++) begin
      set_we  = 4'($urandom) & 4'($urandom);
      clr_we  = 4'($urandom) & 4'($urandom);
      mask_we = ($urandom % 6 == 0) ? 4'(1 << ($urandom % 4)) : 4'h0;
      for (int c = 0; c < 4; c++) begin
        set_data[c*32 +: 32]  = $urandom;
        clr_data[c*32 +: 32]  = $urandom;
        mask_data[c*32 +: 32] = $urandom & $urandom & $urandom;
        fifo_level[c*4 +: 4]  = 4'($urandom % 9);
      end
      wait_req = 4'($urandom);
      @(posedge clk);
      #1;
    end
    set_we = '0; clr_we = '0; mask_we = '0; wait_req = '0;
    fifo_level = '0;

    // R10: reset in mid-run clears flags and masks
    cur_tag = "R10";
    do_set(0, 32'h00FF_FFFF);
    tick();
    rst_n = 1'b0;
    @(posedge clk);
    #1 rst_n = 1'b1;
    wait_req = 4'hF;
    @(negedge clk);
    chk("R10 software bits cleared", events_o, 32'h0500_0000);
    chk("R10 masks cleared", {28'b0, wait_done}, 32'h0);
    tick();
    wait_req = '0;
    repeat (2) @(posedge clk);

    running = 1'b0;
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule